// File: doc/BRIEF.md
# Programmable Video Line-Delay Chain

This block holds the recent lines of a raster so that a vertical filter can see one pixel column across several lines at once. A registered input pixel enters a chain of seven 8-bit line buffers. The registered input and the seven buffer outputs form eight vertically aligned taps. The last buffer feeds a registered cascade output, which can drive the data input of a second chain so that more taps are available. An optional eighth buffer serves a second field. It can take data from its own input port, or it can extend the main chain.

Every buffer is a circular memory with one shared read/write pointer. A 12-bit configuration word sets the line length. The buffers can run in three ways. In delay mode each buffer feeds the next. In recirculate mode each buffer feeds its own output back to its input, so its stored line can be read again and again. In parallel preload mode every buffer takes the registered input at the same time. A shift-hold input freezes the whole chain. A cascade option makes the first buffer two pixels shorter, which makes up for the extra input and cascade-output register stages between two chained instances. The configuration inputs are registered on every clock, whatever the hold input does. A change of length or of cascade option resets all pointers.

Top module: `vid_line_chain`

## Requirements
- R1: Every buffer length is the configuration word plus 4, which gives lengths from 4 up to the parameter MAX_LEN. A word whose sum is above MAX_LEN is clamped to MAX_LEN.
- R2: In delay mode, tap 0 is the input pixel registered on the last enabled edge. Tap k (k = 1..7) equals tap 0 as it was k·L enabled edges earlier, where L is the line length.
- R3: In recirculate mode each buffer takes its own output as its input. After the switch, each tap repeats the line it held at the switch, with a period of L enabled edges.
- R4: In parallel preload mode every main buffer takes the registered input. After L enabled edges, all of taps 1..7 equal tap 0 from L enabled edges earlier.
- R5: While shift_hold_i is high at a clock edge, the input registers, all buffers, the pointers and the cascade output keep their values. Input data presented on those edges is ignored.
- R6: With cascade mode set, the first buffer is L−2 long and the other buffers stay L long, so tap k equals tap 0 from k·L−2 enabled edges earlier.
- R7: cas_o is registered. After each enabled edge it holds the value tap 7 had before that edge.
- R8: With the field buffer disabled, fld_tap_o is 0 and that buffer does not advance. With the buffer and the field port both enabled, the buffer is fed from the registered fld_din_i in delay and parallel modes, so fld_tap_o equals the field input from L edges earlier. With the port disabled, the buffer extends the main chain and fld_tap_o equals tap 0 from 8·L edges earlier.
- R9: After reset, tap 0, cas_o and fld_tap_o are 0, the length is 4, and every mode is off.
- R10: A configuration takes effect on the edge after it is presented. A change of length or of cascade option resets all pointers, and the taps are correct again once the chain has been refilled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_hold_i | input | 1 | High: freeze the input registers, buffers and cascade output |
| len_cfg_i | input | CFG_W (12) | Line length minus 4 |
| recirc_i | input | 1 | Recirculate mode |
| par_load_i | input | 1 | Parallel preload mode |
| fld_port_en_i | input | 1 | Field buffer is fed from the field input port |
| fld_buf_en_i | input | 1 | Enable the field buffer |
| cascade_i | input | 1 | Shorten the first buffer by two |
| din_i | input | DW (8) | Primary pixel input |
| fld_din_i | input | DW (8) | Second-field pixel input |
| taps_o | output | (NBUF+1)·DW (64) | Tap k in bits [k·DW +: DW]; tap 0 is the registered input |
| fld_tap_o | output | DW (8) | Field buffer output, 0 when disabled |
| cas_o | output | DW (8) | Registered cascade output |

## Verification
The bench keeps a history of the accepted inputs and derives each tap from it, using offsets of k·L, k·L−2 or L. It goes after the ends of the length range: the minimum length of 4, and a word far above the maximum, which a design without the clamp would wrap to a short length and so produce the wrong taps. Hold cycles with changing input are inserted between enabled cycles. A design that let the pointer or the input register move would shift every later tap by one. The recirculate and parallel phases start on a chain already filled in delay mode. A mux that took the wrong source would show either the still-advancing input stream or a tap that was only one line deep. Cascade mode and the two field-buffer sources are each run after a pointer reset, which catches an off-by-two first buffer or a field buffer that took its data from the wrong place.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

  // Registered operating mode of the chain.
  typedef struct packed {
    logic recirc;    // buffers feed themselves
    logic par_load;  // all main buffers take the input register
    logic fld_port;  // field buffer fed from the second port
    logic fld_buf;   // field buffer enabled
    logic cascade;   // first buffer shortened by two
  } lcd_mode_t;

  localparam int unsigned LCD_LEN_OFS  = 4;
  localparam int unsigned LCD_CAS_TRIM = 2;

endpackage

// File: rtl/lcd_cfg.sv
module lcd_cfg
  import lcd_pkg::*;
#(
  parameter int unsigned CFG_W   = 12,
  parameter int unsigned MAX_LEN = 64,
  parameter int unsigned LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] len_cfg_i,
  input  lcd_mode_t        mode_i,
  output logic [LEN_W-1:0] len_o,
  output logic [LEN_W-1:0] first_len_o,
  output lcd_mode_t        mode_o,
  output logic             restart_o
);

  localparam int unsigned SUM_W = CFG_W + 1;

  logic [SUM_W-1:0] len_sum;
  logic [LEN_W-1:0] len_n, len_q;
  lcd_mode_t        mode_q;

  // Length decode with clamp to the physical depth.
  always_comb begin
    len_sum = {1'b0, len_cfg_i} + SUM_W'(LCD_LEN_OFS);
    if (len_sum > SUM_W'(MAX_LEN)) len_n = LEN_W'(MAX_LEN);
    else                           len_n = len_sum[LEN_W-1:0];
  end

  // A change of any pointer-wrap point restarts every buffer.
  assign restart_o = (len_n != len_q) || (mode_i.cascade != mode_q.cascade);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= LEN_W'(LCD_LEN_OFS);
      mode_q <= '0;
    end else begin
      len_q  <= len_n;
      mode_q <= mode_i;
    end
  end

  assign len_o       = len_q;
  assign mode_o      = mode_q;
  assign first_len_o = mode_q.cascade ? (len_q - LEN_W'(LCD_CAS_TRIM)) : len_q;

  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(len_q) >= 4) && (int'(len_q) <= int'(MAX_LEN))); // R1
  AST_LEN_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    ((int'(len_cfg_i) + 4) <= int'(MAX_LEN)) |=> (int'(len_q) == int'($past(len_cfg_i)) + 4)); // R1
  AST_LEN_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    ((int'(len_cfg_i) + 4) > int'(MAX_LEN)) |=> (int'(len_q) == int'(MAX_LEN))); // R1

endmodule

// File: rtl/lcd_line_buf.sv
module lcd_line_buf #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 64,
  parameter int unsigned LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  input  logic             restart_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [DW-1:0]    din_i,
  output logic [DW-1:0]    dout_o
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] ptr_q, ptr_n;
  logic [LEN_W-1:0] last_idx;

  assign last_idx = len_i - LEN_W'(1);

  always_comb begin
    ptr_n = ptr_q;
    if (restart_i)                           ptr_n = '0;
    else if (adv_i && (LEN_W'(ptr_q) == last_idx)) ptr_n = '0;
    else if (adv_i)                          ptr_n = ptr_q + PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_n;
  end

  // Storage: read the oldest entry, then overwrite it on advance.
  always_ff @(posedge clk) begin
    if (adv_i) mem[ptr_q] <= din_i;
  end

  assign dout_o = mem[ptr_q];

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    LEN_W'(ptr_q) < len_i); // R1
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !restart_i) |=> $stable(ptr_q)); // R5
  AST_PTR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (ptr_q == '0)); // R10

endmodule

// File: rtl/vid_line_chain.sv
module vid_line_chain
  import lcd_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter int unsigned NBUF    = 7,
  parameter int unsigned CFG_W   = 12,
  parameter int unsigned MAX_LEN = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   shift_hold_i,
  input  logic [CFG_W-1:0]       len_cfg_i,
  input  logic                   recirc_i,
  input  logic                   par_load_i,
  input  logic                   fld_port_en_i,
  input  logic                   fld_buf_en_i,
  input  logic                   cascade_i,
  input  logic [DW-1:0]          din_i,
  input  logic [DW-1:0]          fld_din_i,
  output logic [(NBUF+1)*DW-1:0] taps_o,
  output logic [DW-1:0]          fld_tap_o,
  output logic [DW-1:0]          cas_o
);

  localparam int unsigned LEN_W = $clog2(MAX_LEN + 1);

  lcd_mode_t        mode_in, mode_q;
  logic [LEN_W-1:0] len_q, first_len;
  logic             restart;
  logic             adv;
  logic [DW-1:0]    din_q, fld_q, cas_q;
  logic [DW-1:0]    buf_out [NBUF];
  logic [DW-1:0]    fld_src, fld_out;

  assign mode_in = '{recirc:   recirc_i,
                     par_load: par_load_i,
                     fld_port: fld_port_en_i,
                     fld_buf:  fld_buf_en_i,
                     cascade:  cascade_i};

  lcd_cfg #(.CFG_W(CFG_W), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .len_cfg_i   (len_cfg_i),
    .mode_i      (mode_in),
    .len_o       (len_q),
    .first_len_o (first_len),
    .mode_o      (mode_q),
    .restart_o   (restart)
  );

  assign adv = !shift_hold_i;

  // Input and cascade registers, clock-enabled by the shift enable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din_q <= '0;
      fld_q <= '0;
      cas_q <= '0;
    end else if (adv) begin
      din_q <= din_i;
      fld_q <= fld_din_i;
      cas_q <= buf_out[NBUF-1];
    end
  end

  assign taps_o[DW-1:0] = din_q;

  for (genvar k = 0; k < NBUF; k++) begin : g_buf
    logic [DW-1:0]    prev;
    logic [DW-1:0]    src;
    logic [LEN_W-1:0] blen;

    if (k == 0) begin : g_head
      assign prev = din_q;
      assign blen = first_len;
    end else begin : g_body
      assign prev = buf_out[k-1];
      assign blen = len_q;
    end

    always_comb begin
      if (mode_q.recirc)        src = buf_out[k];
      else if (mode_q.par_load) src = din_q;
      else                      src = prev;
    end

    lcd_line_buf #(.DW(DW), .DEPTH(MAX_LEN), .LEN_W(LEN_W)) u_lb (
      .clk       (clk),
      .rst_n     (rst_n),
      .adv_i     (adv),
      .restart_i (restart),
      .len_i     (blen),
      .din_i     (src),
      .dout_o    (buf_out[k])
    );

    assign taps_o[(k+1)*DW +: DW] = buf_out[k];
  end

  // Field buffer: own port, parallel source, or chain extension.
  always_comb begin
    if (mode_q.recirc)        fld_src = fld_out;
    else if (mode_q.fld_port) fld_src = fld_q;
    else if (mode_q.par_load) fld_src = din_q;
    else                      fld_src = buf_out[NBUF-1];
  end

  lcd_line_buf #(.DW(DW), .DEPTH(MAX_LEN), .LEN_W(LEN_W)) u_fld (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv_i     (adv && mode_q.fld_buf),
    .restart_i (restart),
    .len_i     (len_q),
    .din_i     (fld_src),
    .dout_o    (fld_out)
  );

  assign fld_tap_o = mode_q.fld_buf ? fld_out : '0;
  assign cas_o     = cas_q;

  AST_CAS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    shift_hold_i |=> $stable(cas_o)); // R5
  AST_TAP0_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    shift_hold_i |=> $stable(taps_o[DW-1:0])); // R5
  AST_CAS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_hold_i |=> (cas_o == $past(buf_out[NBUF-1]))); // R7
  AST_FLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !fld_buf_en_i |=> (fld_tap_o == '0)); // R8

endmodule

// File: tb/sim_vid_line_chain.sv
`timescale 1ns/1ps
module sim_vid_line_chain;

  localparam int DW = 8;
  localparam int MAXL = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        shift_hold_i;
  logic [11:0] len_cfg_i;
  logic        recirc_i, par_load_i, fld_port_en_i, fld_buf_en_i, cascade_i;
  logic [7:0]  din_i, fld_din_i;
  logic [63:0] taps_o;
  logic [7:0]  fld_tap_o, cas_o;

  always #2.5 clk = ~clk;

  vid_line_chain u0 (
    .clk(clk), .rst_n(rst_n), .shift_hold_i(shift_hold_i), .len_cfg_i(len_cfg_i),
    .recirc_i(recirc_i), .par_load_i(par_load_i), .fld_port_en_i(fld_port_en_i),
    .fld_buf_en_i(fld_buf_en_i), .cascade_i(cascade_i), .din_i(din_i),
    .fld_din_i(fld_din_i), .taps_o(taps_o), .fld_tap_o(fld_tap_o), .cas_o(cas_o)
  );

  typedef struct packed {
    logic [63:0] taps;
    logic [7:0]  fld;
    logic [7:0]  cas;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    failures = 0;

  // Reference model state, indexed by enabled edges.
  logic [7:0] hd [0:8191];
  logic [7:0] hv [0:8191];
  int m = 0, L = 4, R = 0, S = 0, P = 0, mode = 0;
  bit casc = 0, fbuf = 0, fport = 0;
  bit fresh = 0;

  // Pending configuration, driven at the next step.
  int  n_cfg = 0;
  bit  n_rec = 0, n_par = 0, n_fport = 0, n_fbuf = 0, n_casc = 0;
  bit  pend = 0;
  string cur_tag = "R2";

  function automatic int len_of(int cfg);
    return (cfg + 4 > MAXL) ? MAXL : cfg + 4;
  endfunction

  function automatic logic [7:0] tap_x(int k, int mm);
    int t;
    t = mm;
    if (k == 0) return hd[mm];
    if (mode == 2 && mm >= P + L) return hd[mm - L];
    if (mode == 1 && mm >= S) t = S + ((mm - S) % L);
    return hd[t - k * L + (casc ? 2 : 0)];
  endfunction

  function automatic logic [7:0] fld_x(int mm);
    int t;
    t = mm;
    if (!fbuf) return 8'h00;
    if (fport) return hv[mm - L];
    if (mode == 2 && mm >= P + L) return hd[mm - L];
    if (mode == 1 && mm >= S) t = S + ((mm - S) % L);
    return hd[t - 8 * L + (casc ? 2 : 0)];
  endfunction

  task automatic apply(int cfg, bit rec, bit par, bit fp, bit fb, bit cs, string tag);
    n_cfg = cfg; n_rec = rec; n_par = par; n_fport = fp; n_fbuf = fb; n_casc = cs;
    pend = 1; cur_tag = tag;
  endtask

  // Driver: present one cycle, update the model, push the expectation.
  task automatic step(logic [7:0] d, logic [7:0] v, bit hold);
    exp_t e;
    bit   was_pend, valid;
    int   newL, newmode;
    @(negedge clk);
    din_i = d; fld_din_i = v; shift_hold_i = hold;
    len_cfg_i = 12'(n_cfg); recirc_i = n_rec; par_load_i = n_par;
    fld_port_en_i = n_fport; fld_buf_en_i = n_fbuf; cascade_i = n_casc;
    was_pend = pend; pend = 0;
    @(posedge clk);
    if (!hold) begin
      m++; hd[m] = d; hv[m] = v;
    end
    if (was_pend) begin
      newL = len_of(n_cfg);
      newmode = n_rec ? 1 : (n_par ? 2 : 0);
      if (newL != L || n_casc != casc) begin
        R = m; fresh = 1;
      end
      if (newmode == 1 && mode != 1) S = m;
      if (newmode == 2 && mode != 2) P = m;
      L = newL; casc = n_casc; fbuf = n_fbuf; fport = n_fport; mode = newmode;
    end
    valid = (m - R >= 8 * L + 4);
    if (mode == 2 && m < P + L + 1) valid = 0;
    if (valid) begin
      for (int k = 0; k < 8; k++) e.taps[k*8 +: 8] = tap_x(k, m);
      e.fld = fld_x(m);
      e.cas = tap_x(7, m - 1);
      exp_q.push_back(e);
      if (fresh) begin
        tag_q.push_back({"R10 ", cur_tag});
        fresh = 0;
      end else if (hold) tag_q.push_back({"R5 ", cur_tag});
      else tag_q.push_back(cur_tag);
    end
  endtask

  task automatic run(int n, bit with_holds);
    for (int i = 0; i < n; i++) begin
      step(8'($urandom), 8'($urandom), with_holds && (i % 7 == 3));
    end
  endtask

  // Monitor: compare away from the active edge.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (taps_o !== e.taps || fld_tap_o !== e.fld || cas_o !== e.cas) begin
        failures++;
        $display("FAIL %s: taps=%h fld=%h cas=%h expected taps=%h fld=%h cas=%h",
                 t, taps_o, fld_tap_o, cas_o, e.taps, e.fld, e.cas);
      end
    end
  end

  initial begin
    #(5 * 150000);
    failures++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; shift_hold_i = 1'b1; len_cfg_i = '0;
    recirc_i = 0; par_load_i = 0; fld_port_en_i = 0; fld_buf_en_i = 0; cascade_i = 0;
    din_i = '0; fld_din_i = '0;
    for (int i = 0; i < 8192; i++) begin hd[i] = 8'h00; hv[i] = 8'h00; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state of the registered outputs
    checks++;
    if (taps_o[7:0] !== 8'h00 || cas_o !== 8'h00 || fld_tap_o !== 8'h00) begin
      failures++;
      $display("FAIL R9: tap0=%h cas=%h fld=%h expected 00 00 00",
               taps_o[7:0], cas_o, fld_tap_o);
    end

    // Minimum length, plain delay (R2, R1)
    apply(0, 0, 0, 0, 0, 0, "R2 R1 R7");
    run(60, 0);
    // Length 9 with hold cycles mixed in (R5)
    apply(5, 0, 0, 0, 0, 0, "R2 R7");
    run(140, 1);
    // Over-range word clamps to the maximum (R1)
    apply(4095, 0, 0, 0, 0, 0, "R1 R7");
    run(8 * MAXL + 40, 1);
    // Cascade compensation (R6)
    apply(6, 0, 0, 0, 0, 1, "R6");
    run(120, 1);
    // Fill, then recirculate (R3)
    apply(3, 0, 0, 0, 0, 0, "R2");
    run(70, 0);
    apply(3, 1, 0, 0, 0, 0, "R3");
    run(40, 1);
    // Fill, then parallel preload (R4)
    apply(4, 0, 0, 0, 0, 0, "R2");
    run(75, 0);
    apply(4, 0, 1, 0, 0, 0, "R4");
    run(40, 1);
    // Field buffer on its own port, then with parallel preload (R8)
    apply(2, 0, 0, 1, 1, 0, "R8");
    run(70, 1);
    apply(2, 0, 1, 1, 1, 0, "R8 R4");
    run(30, 0);
    // Field buffer extending the chain (R8)
    apply(1, 0, 0, 0, 1, 0, "R8");
    run(70, 1);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule